// File: doc/BRIEF.md
# Programmable-Depth Tower Puzzle Move Sequencer

This block generates the optimal move list for the three-peg disk-stacking puzzle, one move per clock cycle. All disks start on peg 1, and the goal is to rebuild the whole stack on peg 3. The block is built for a largest disk count `MAX_DISKS`. The active count is supplied with a one-cycle start request.

After an accepted start, the block emits a stream of moves. Each move carries the disk number, the source peg and the destination peg, and the stream contains no gaps. The block then raises a completion flag and waits for the next start.

Internally it keeps a move counter and two peg registers per disk, one for the source and one for the destination, all sized for `MAX_DISKS`. The counter's lowest set bit selects the row of the disk that moves. The per-disk registers always start from the pattern that suits an odd or even `MAX_DISKS`. When the requested count has the other parity, pegs 2 and 3 are exchanged at the outputs. A comparator on the decoded disk number ends the run once that number exceeds the requested count.

Top module: `hanoi_seq`

## Requirements
- R1: A start request with `1 <= depth <= MAX_DISKS` is accepted. In the next cycle `valid` is high, `disk` is 1 and `err` is low.
- R2: An accepted run with depth n produces exactly 2^n - 1 consecutive cycles with `valid` high.
- R3: For move i (i counted from 1), `disk` equals one plus the bit index of the lowest set bit of i. Consecutive moves never move the same disk.
- R4: Every move is legal. The moved disk is the top disk of the source peg, and it is placed on an empty peg or on a larger disk.
- R5: After the last move of a run, all n disks sit on peg 3.
- R6: Pegs are encoded 1, 2 and 3 on the 2-bit `src_peg` and `dst_peg` ports, and source and destination always differ. The first move takes disk 1 from peg 1 to peg 3 when n is odd, and to peg 2 when n is even.
- R7: `done` rises in the cycle after the last valid move. While `done` is high, `valid` stays low, and `done` holds until the next start request.
- R8: A start request with `depth` equal to 0 or greater than `MAX_DISKS` is rejected. In the next cycle `err` is high, `valid` and `done` are low, and the block stays idle. `err` clears on the next accepted start.
- R9: An accepted start during a run abandons that run and begins the new sequence from move 1 with the new depth.
- R10: While and after reset, and until the first start, `valid`, `done` and `err` are low. `disk`, `src_peg` and `dst_peg` read 0 whenever `valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle start request, sampling `depth` |
| depth | input | $clog2(MAX_DISKS+2) | Requested disk count |
| valid | output | 1 | A move is presented this cycle |
| disk | output | $clog2(MAX_DISKS+2) | Number of the disk being moved (1 = smallest) |
| src_peg | output | 2 | Peg the disk leaves (1..3) |
| dst_peg | output | 2 | Peg the disk lands on (1..3) |
| done | output | 1 | Sequence finished, held until next start |
| err | output | 1 | Last start request carried an illegal depth |

## Verification
The first move appears in the cycle after the edge that samples `start`. Each following move comes one cycle later. `done` follows the last move by one cycle, and `err` follows a rejected request by one cycle.

The bench drives `start` just after a rising edge and drops it after the next one. It samples every output on the falling edge, so each sample falls in the cycle where that result is due. A scoreboard queue, filled from a closed-form move formula when the run starts, is popped once per sampled valid cycle. A peg-stack model checks legality and the final stack.

// File: rtl/hanoi_pkg.sv
package hanoi_pkg;

    typedef logic [1:0] peg_t;

    localparam peg_t PEG_NONE  = 2'd0;
    localparam peg_t PEG_LEFT  = 2'd1;
    localparam peg_t PEG_MID   = 2'd2;
    localparam peg_t PEG_RIGHT = 2'd3;

    typedef struct packed {
        peg_t src;
        peg_t dst;
    } peg_pair_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;

    // With pegs coded 1..3, the remaining peg is the XOR of the other two.
    function automatic peg_t third_peg(input peg_t a, input peg_t b);
        return a ^ b;
    endfunction

    // Exchange pegs 2 and 3 when enabled; peg 1 and code 0 pass unchanged.
    function automatic peg_t swap_mid_right(input peg_t p, input logic en);
        return (en && p[1]) ? (p ^ 2'b01) : p;
    endfunction

    // Initial destination of disk d (1-based) for a stack of max_d disks.
    function automatic peg_t init_dest(input int max_d, input int d);
        return (((max_d - d) % 2) == 0) ? PEG_RIGHT : PEG_MID;
    endfunction

endpackage

// File: rtl/hanoi_move_counter.sv
module hanoi_move_counter #(
    parameter int MAX_DISKS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    output logic [MAX_DISKS:0] row_sel
);
    localparam int CW = MAX_DISKS + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] tgl;
    logic [CW-1:0] low_zero;

    assign tgl[0]      = 1'b1;
    assign low_zero[0] = 1'b1;

    generate
        for (genvar k = 1; k < CW; k++) begin : g_chain
            assign tgl[k]      = tgl[k-1] & cnt[k-1];
            assign low_zero[k] = low_zero[k-1] & ~cnt[k-1];
        end
        for (genvar k = 0; k < CW; k++) begin : g_row
            assign row_sel[k] = cnt[k] & low_zero[k];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= {{MAX_DISKS{1'b0}}, 1'b1};
        end else if (advance) begin
            cnt <= cnt ^ tgl;
        end
    end

    // R1
    cleared_row_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> row_sel[0]);

    // R3
    step_moves_row_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !clear) |=> (row_sel != $past(row_sel)));

endmodule

// File: rtl/hanoi_peg_rows.sv
module hanoi_peg_rows
    import hanoi_pkg::*;
#(
    parameter int MAX_DISKS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 step,
    input  logic [MAX_DISKS-1:0] row_sel,
    output peg_pair_t            bus
);
    logic [MAX_DISKS-1:0][1:0] src_v;
    logic [MAX_DISKS-1:0][1:0] dst_v;

    generate
        for (genvar r = 0; r < MAX_DISKS; r++) begin : g_row
            localparam peg_t INIT_DST = init_dest(MAX_DISKS, r + 1);
            peg_t src_q;
            peg_t dst_q;

            always_ff @(posedge clk) begin
                if (rst || load) begin
                    src_q <= PEG_LEFT;
                    dst_q <= INIT_DST;
                end else if (step && row_sel[r]) begin
                    src_q <= dst_q;
                    dst_q <= third_peg(src_q, dst_q);
                end
            end

            assign src_v[r] = src_q;
            assign dst_v[r] = dst_q;
        end
    endgenerate

    always_comb begin
        bus = '0;
        for (int r = 0; r < MAX_DISKS; r++) begin
            bus.src = bus.src | (src_v[r] & {2{row_sel[r]}});
            bus.dst = bus.dst | (dst_v[r] & {2{row_sel[r]}});
        end
    end

    // R6
    row_pegs_distinct_chk: assert property (@(posedge clk) disable iff (rst)
        (|row_sel) |-> (bus.src != bus.dst && bus.src != PEG_NONE && bus.dst != PEG_NONE));

    // R3
    single_row_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_sel));

endmodule

// File: rtl/hanoi_disk_encoder.sv
module hanoi_disk_encoder #(
    parameter int MAX_DISKS = 8,
    parameter int DW        = $clog2(MAX_DISKS + 2)
) (
    input  logic [MAX_DISKS:0] row_sel,
    output logic [DW-1:0]      disk_num
);
    always_comb begin
        disk_num = '0;
        for (int k = 0; k <= MAX_DISKS; k++) begin
            if (row_sel[k]) begin
                disk_num = disk_num | DW'(k + 1);
            end
        end
    end
endmodule

// File: rtl/hanoi_seq.sv
module hanoi_seq
    import hanoi_pkg::*;
#(
    parameter int MAX_DISKS = 8,
    localparam int DW       = $clog2(MAX_DISKS + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] depth,
    output logic          valid,
    output logic [DW-1:0] disk,
    output logic [1:0]    src_peg,
    output logic [1:0]    dst_peg,
    output logic          done,
    output logic          err
);
    localparam logic MAX_ODD = MAX_DISKS[0];

    seq_state_e           state_q;
    logic [DW-1:0]        n_q;
    logic                 swap_q;
    logic                 err_q;
    logic                 accept;
    logic                 term;
    logic                 step;
    logic [MAX_DISKS:0]   row_sel;
    logic [DW-1:0]        disk_num;
    peg_pair_t            bus;

    assign accept = start && (depth != '0) && (depth <= DW'(MAX_DISKS));
    assign term   = disk_num > n_q;
    assign step   = (state_q == SEQ_RUN) && !term;

    hanoi_move_counter #(.MAX_DISKS(MAX_DISKS)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .advance (step),
        .row_sel (row_sel)
    );

    hanoi_peg_rows #(.MAX_DISKS(MAX_DISKS)) u_rows (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .step    (step),
        .row_sel (row_sel[MAX_DISKS-1:0]),
        .bus     (bus)
    );

    hanoi_disk_encoder #(.MAX_DISKS(MAX_DISKS), .DW(DW)) u_enc (
        .row_sel  (row_sel),
        .disk_num (disk_num)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            n_q     <= '0;
            swap_q  <= 1'b0;
            err_q   <= 1'b0;
        end else if (start) begin
            if (accept) begin
                state_q <= SEQ_RUN;
                n_q     <= depth;
                swap_q  <= depth[0] != MAX_ODD;
                err_q   <= 1'b0;
            end else begin
                state_q <= SEQ_IDLE;
                err_q   <= 1'b1;
            end
        end else if (state_q == SEQ_RUN && term) begin
            state_q <= SEQ_FIN;
        end
    end

    assign valid   = step;
    assign done    = (state_q == SEQ_FIN) || (state_q == SEQ_RUN && term);
    assign err     = err_q;
    assign disk    = step ? disk_num : '0;
    assign src_peg = step ? swap_mid_right(bus.src, swap_q) : PEG_NONE;
    assign dst_peg = step ? swap_mid_right(bus.dst, swap_q) : PEG_NONE;

    // R1
    first_move_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (valid && disk == DW'(1) && !err));

    // R3
    no_repeat_disk_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !start) |=> (!valid || disk != $past(disk)));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && !valid));

    // R8
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !accept) |=> (err && !valid && !done));

    // R6
    out_pegs_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> (src_peg != dst_peg && src_peg != PEG_NONE && dst_peg != PEG_NONE));

endmodule

// File: tb/tb_hanoi_seq.sv
module tb_hanoi_seq;
    localparam int MAXD = 8;
    localparam int DW   = $clog2(MAXD + 2);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [DW-1:0] depth = '0;
    logic          valid;
    logic [DW-1:0] disk;
    logic [1:0]    src_peg;
    logic [1:0]    dst_peg;
    logic          done;
    logic          err;

    int checks = 0;
    int errors = 0;
    int moves_seen = 0;
    bit finished = 0;

    int exp_q[$];
    int stk[1:3][0:MAXD-1];
    int hgt[1:3];

    always #5 clk = ~clk;

    hanoi_seq #(.MAX_DISKS(MAXD)) dut (
        .clk(clk), .rst(rst), .start(start), .depth(depth),
        .valid(valid), .disk(disk), .src_peg(src_peg), .dst_peg(dst_peg),
        .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Closed-form expected move, encoded as disk*16 + src*4 + dst.
    function automatic int ref_move(input int n, input int i);
        int s0, d0, dk, sp, dp;
        s0 = (i & (i - 1)) % 3;
        d0 = ((i | (i - 1)) + 1) % 3;
        dk = 1;
        while (((i >> (dk - 1)) & 1) == 0) dk++;
        sp = s0 + 1;
        dp = d0 + 1;
        if (n % 2 == 0) begin
            if (sp > 1) sp = 5 - sp;
            if (dp > 1) dp = 5 - dp;
        end
        return dk * 16 + sp * 4 + dp;
    endfunction

    task automatic start_run(input int n);
        @(posedge clk);
        #1;
        start = 1'b1;
        depth = DW'(n);
        @(posedge clk);
        #1;
        start = 1'b0;
        exp_q.delete();
        for (int i = 1; i < (1 << n); i++) exp_q.push_back(ref_move(n, i));
        for (int p = 1; p <= 3; p++) hgt[p] = 0;
        for (int d = n; d >= 1; d--) begin
            stk[1][hgt[1]] = d;
            hgt[1]++;
        end
        moves_seen = 0;
    endtask

    // Monitor: pops the scoreboard and tracks the peg stacks.
    always @(negedge clk) begin
        if (!rst && valid) begin
            int e, sp, dp;
            sp = int'(src_peg);
            dp = int'(dst_peg);
            moves_seen++;
            if (exp_q.size() == 0) begin
                check(0, "R2 extra move", moves_seen, 0);
            end else begin
                e = exp_q.pop_front();
                check(int'(disk) == e / 16, "R3 disk", int'(disk), e / 16);
                check(sp * 4 + dp == e % 16, "R6 src*4+dst", sp * 4 + dp, e % 16);
            end
            if (sp >= 1 && dp >= 1 && sp != dp) begin
                check(hgt[sp] > 0 && stk[sp][hgt[sp]-1] == int'(disk), "R4 top of source",
                      hgt[sp] > 0 ? stk[sp][hgt[sp]-1] : 0, int'(disk));
                check(hgt[dp] == 0 || stk[dp][hgt[dp]-1] > int'(disk), "R4 onto larger",
                      hgt[dp] > 0 ? stk[dp][hgt[dp]-1] : 0, int'(disk));
                if (hgt[sp] > 0) hgt[sp]--;
                if (hgt[dp] < MAXD) begin
                    stk[dp][hgt[dp]] = int'(disk);
                    hgt[dp]++;
                end
            end else begin
                check(0, "R6 peg codes", sp * 4 + dp, 0);
            end
        end
    end

    task automatic wait_done(input int n);
        int guard = 0;
        while (!done && guard < (1 << (n + 1)) + 8) begin
            @(negedge clk);
            guard++;
        end
        check(done, "R7 done raised", done, 1);
        check(!valid, "R7 valid low at done", valid, 0);
        check(moves_seen == (1 << n) - 1, "R2 move count", moves_seen, (1 << n) - 1);
        check(hgt[3] == n, "R5 disks on peg 3", hgt[3], n);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(done && !valid, "R7 done holds", {done, valid}, 2);
        end
    endtask

    task automatic bad_start(input int n);
        @(posedge clk);
        #1;
        start = 1'b1;
        depth = DW'(n);
        @(posedge clk);
        #1;
        start = 1'b0;
        @(negedge clk);
        check(err, "R8 err raised", err, 1);
        check(!valid && !done, "R8 idle", {valid, done}, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!valid && disk == '0 && src_peg == 2'd0, "R8 stays idle R10", int'(disk), 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(!valid && !done && !err, "R10 reset state", {valid, done, err}, 0);
        check(disk == '0 && src_peg == 2'd0 && dst_peg == 2'd0, "R10 idle outputs", int'(disk), 0);

        for (int n = 1; n <= MAXD; n++) begin
            start_run(n);
            @(negedge clk);
            check(valid && disk == DW'(1), "R1 first move", int'(disk), 1);
            check(!err, "R1 err low", err, 0);
            check(int'(dst_peg) == ((n % 2 == 1) ? 3 : 2), "R6 first destination",
                  int'(dst_peg), (n % 2 == 1) ? 3 : 2);
            wait_done(n);
        end

        bad_start(0);
        bad_start(MAXD + 1);
        start_run(2);
        @(negedge clk);
        check(!err, "R8 err cleared", err, 0);
        wait_done(2);

        // R9 restart in the middle of a run
        start_run(MAXD);
        repeat (5) @(negedge clk);
        start_run(3);
        @(negedge clk);
        check(valid && disk == DW'(1), "R9 restart first move", int'(disk), 1);
        wait_done(3);

        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end
endmodule